// File: doc/BRIEF.md
# I2C Register-Write Target with Atomic Multi-Byte Commit

This block is an I2C target that only accepts writes. It watches SCL and SDA through synchronisers and finds START and STOP conditions. Once it sees its own 7-bit device address with the write bit, it takes one subaddress byte and then any number of data bytes. It acknowledges every accepted byte by pulling SDA low during the ninth clock.

The incoming data bytes collect in a staging register. The length of each register comes from a parameter rule: subaddresses from `WIDE_LO` to `WIDE_HI` hold `WORD_BYTES` bytes, and every other subaddress holds one byte. A register is written to the register file only when its last byte arrives. The subaddress then steps forward by one, so a long burst fills consecutive registers in turn. A register that is only partly received when a STOP or repeated START arrives is dropped. Every register finished before that point stays written.

The register-file write port is a one-cycle strobe with address and data. It has no ready signal and applies no back-pressure: I2C without clock stretching cannot pause the master, so the register file must accept a write in any cycle. Two writes are always many cycles apart, because each data byte takes at least nine SCL periods to arrive.

Top module: `i2cw_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and `wr_valid` is 0.
- R2: A first byte equal to `{DEV_ADDR, 1'b0}` (default `0x74`) is acknowledged during the ninth clock. Any other first byte, including the read bit (LSB = 1), is not acknowledged. After such a byte the block does not acknowledge and does not write anything until the next START.
- R3: In an accepted transfer, the subaddress byte and every data byte are acknowledged. `sda_oe` is high only during the acknowledge bit.
- R4: A register outside `WIDE_LO..WIDE_HI` (default `0x10..0x1F`) holds one byte. It is written with that byte in `wr_data[7:0]` and zeros above.
- R5: A register inside `WIDE_LO..WIDE_HI` holds `WORD_BYTES` bytes (default 4), received most significant byte first. It is written once, with the full word, after its last byte.
- R6: After each write the subaddress increases by one and wraps from `0xFF` to `0x00`. The next data bytes go to that next register.
- R7: A register that is partly received when a STOP arrives is not written. Registers completed earlier in the same burst remain written.
- R8: A register that is partly received when a repeated START arrives is not written. The new transfer is then decoded from its address byte.
- R9: One burst can write at least 16 consecutive registers without a new subaddress.
- R10: `wr_valid` is high for exactly one clock cycle per written register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | 1 drives SDA low (acknowledge), 0 releases SDA |
| wr_valid | output | 1 | One-cycle register-file write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8*WORD_BYTES | Register word of the write, right-aligned |

## Verification
The hardest cases to reach are the dropped registers. The stimulus must end a burst after a multi-byte register has started but before it is complete, and at least one earlier register must already be committed. The stimulus table has a burst that starts two single-byte registers below the wide range and sends one byte more than a full wide register. Its last byte is left alone in the next wide register when the STOP arrives. A directed test breaks off a wide register with a repeated START and follows it at once with a new, valid single-byte write. Other table entries cross the `0xFF` to `0x00` wrap, send a 16-register burst, and send a read bit or a foreign address. A directed test checks that a rejected transfer stays silent until a repeated START brings back the correct address.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_SUB,
    LK_DATA,
    LK_SKIP
  } link_state_t;

  // Byte count of the register at a subaddress.
  function automatic logic [3:0] reg_bytes(input logic [7:0] a,
                                           input logic [7:0] lo,
                                           input logic [7:0] hi,
                                           input int unsigned wide);
    return (a >= lo && a <= hi) ? 4'(wide) : 4'd1;
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_now,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  logic scl_s, scl_q, sda_q;
  assign scl_s   = scl_pipe[STAGES-1];
  assign scl_q   = scl_pipe[STAGES];
  assign sda_now = sda_pipe[STAGES-1];
  assign sda_q   = sda_pipe[STAGES];

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_now;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_now;

endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_now,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  output logic       sda_oe,
  output logic       byte_stb,
  output logic       sub_stb,
  output logic [7:0] byte_q,
  output logic       abort
);
  link_state_t state;
  logic [3:0]  bitcnt;
  logic [6:0]  shreg;
  logic        ack_slot;
  logic        ack_pend;
  logic [7:0]  full_byte;

  assign full_byte = {shreg, sda_now};
  assign abort     = start_ev | stop_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LK_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_slot <= 1'b0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
      byte_stb <= 1'b0;
      sub_stb  <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_stb <= 1'b0;
      sub_stb  <= 1'b0;
      if (start_ev || stop_ev) begin
        state    <= start_ev ? LK_ADDR : LK_IDLE;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        ack_pend <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (state == LK_IDLE || state == LK_SKIP) begin
        sda_oe <= 1'b0;
      end else if (scl_rise && bitcnt < 4'd8) begin
        shreg  <= full_byte[6:0];
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == 4'd7) begin
          case (state)
            LK_ADDR: begin
              if (full_byte == {DEV_ADDR, 1'b0}) begin
                ack_pend <= 1'b1;
                state    <= LK_SUB;
              end else begin
                state <= LK_SKIP;
              end
            end
            LK_SUB: begin
              ack_pend <= 1'b1;
              byte_q   <= full_byte;
              sub_stb  <= 1'b1;
              state    <= LK_DATA;
            end
            default: begin
              ack_pend <= 1'b1;
              byte_q   <= full_byte;
              byte_stb <= 1'b1;
            end
          endcase
        end
      end else if (scl_fall && bitcnt == 4'd8) begin
        if (!ack_slot) begin
          ack_slot <= 1'b1;
          sda_oe   <= ack_pend;
        end else begin
          ack_slot <= 1'b0;
          sda_oe   <= 1'b0;
          ack_pend <= 1'b0;
          bitcnt   <= '0;
        end
      end
    end
  end

  // R3
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> bitcnt == 4'd8);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_SKIP) |-> !sda_oe && !byte_stb && !sub_stb);

endmodule

// File: rtl/i2cw_regasm.sv
module i2cw_regasm
  import i2cw_pkg::*;
#(
  parameter int         WORD_BYTES = 4,
  parameter logic [7:0] WIDE_LO    = 8'h10,
  parameter logic [7:0] WIDE_HI    = 8'h1F,
  localparam int        DW         = 8 * WORD_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic          sub_stb,
  input  logic [7:0]    byte_q,
  input  logic          abort,
  output logic          wr_valid,
  output logic [7:0]    wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [7:0]    sub_ptr;
  logic [3:0]    fill;
  logic [DW-1:0] stage;
  logic [DW-1:0] next_word;
  logic [3:0]    need;
  logic          last;

  assign need = reg_bytes(sub_ptr, WIDE_LO, WIDE_HI, WORD_BYTES);
  assign last = (fill + 4'd1) == need;

  generate
    if (WORD_BYTES > 1) begin : g_wide
      assign next_word = (fill == 4'd0) ? DW'(byte_q) : {stage[DW-9:0], byte_q};
    end else begin : g_narrow
      assign next_word = byte_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_ptr  <= '0;
      fill     <= '0;
      stage    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (abort) begin
        fill <= '0;
      end else if (sub_stb) begin
        sub_ptr <= byte_q;
        fill    <= '0;
      end else if (byte_stb) begin
        if (last) begin
          wr_valid <= 1'b1;
          wr_addr  <= sub_ptr;
          wr_data  <= next_word;
          sub_ptr  <= sub_ptr + 8'd1;
          fill     <= '0;
        end else begin
          stage <= next_word;
          fill  <= fill + 4'd1;
        end
      end
    end
  end

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R6
  incr_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sub_ptr == wr_addr + 8'd1);

  // R4
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && reg_bytes(wr_addr, WIDE_LO, WIDE_HI, WORD_BYTES) == 4'd1)
      |-> (wr_data >> 8) == '0);

  // R7
  drop_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> fill == 4'd0 && !wr_valid);

endmodule

// File: rtl/i2cw_target.sv
module i2cw_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         WORD_BYTES  = 4,
  parameter logic [7:0] WIDE_LO     = 8'h10,
  parameter logic [7:0] WIDE_HI     = 8'h1F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  output logic                    wr_valid,
  output logic [7:0]              wr_addr,
  output logic [8*WORD_BYTES-1:0] wr_data
);
  logic sda_now, scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_stb, sub_stb, abort;
  logic [7:0] byte_q;

  i2cw_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_now(sda_now), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cw_link #(.DEV_ADDR(DEV_ADDR)) i_link (
    .clk(clk), .rst_n(rst_n), .sda_now(sda_now), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_oe(sda_oe), .byte_stb(byte_stb), .sub_stb(sub_stb),
    .byte_q(byte_q), .abort(abort)
  );

  i2cw_regasm #(.WORD_BYTES(WORD_BYTES), .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI)) i_regasm (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .sub_stb(sub_stb),
    .byte_q(byte_q), .abort(abort), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

endmodule

// File: tb/test_i2cw_target.sv
`timescale 1ns/1ps
module test_i2cw_target;
  localparam int H  = 10;
  localparam int NV = 8;
  // {first byte, subaddress, data byte count}
  localparam logic [23:0] VEC [NV] = '{
    24'h74_05_01,  // R4 single narrow
    24'h74_10_04,  // R5 one wide
    24'h74_0E_07,  // R6 R7 narrow, narrow, wide, partial wide
    24'h74_FE_03,  // R6 wrap
    24'h75_05_02,  // R2 read bit
    24'h72_05_02,  // R2 foreign address
    24'h74_20_10,  // R9 sixteen registers
    24'h74_1C_08   // R5 two wide in a row
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m;
  logic sda_oe, wr_valid;
  logic [7:0] wr_addr;
  logic [31:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  i2cw_target i_i2cw_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  log_a [64];
  logic [31:0] log_d [64];
  int log_n;
  logic log_clr;
  logic [7:0]  ea [64];
  logic [31:0] ed [64];
  int en;

  always @(posedge clk) begin
    if (log_clr) log_n <= 0;
    else if (rst_n && wr_valid) begin
      if (log_n < 64) begin
        log_a[log_n] <= wr_addr;
        log_d[log_n] <= wr_data;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    log_clr = 1'b1; tick(1); log_clr = 1'b0;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    acked = !sda_line;
    tick(H/2);
    scl_m = 1'b0; tick(2);
  endtask

  function automatic int reg_len(input logic [7:0] a);
    return (a >= 8'h10 && a <= 8'h1F) ? 4 : 1;
  endfunction

  task automatic check_log(input string tag);
    chk(log_n == en, {tag, " write count"}, log_n, en);
    for (int i = 0; i < en && i < log_n; i++) begin
      chk(log_a[i] == ea[i], {tag, " write address"}, log_a[i], ea[i]);
      chk(log_d[i] == ed[i], {tag, " write data"}, log_d[i], ed[i]);
    end
  endtask

  initial begin
    bit ack;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; log_clr = 1'b1;
    tick(5);
    // R1
    chk(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
    chk(wr_valid == 1'b0, "R1 wr_valid at reset", wr_valid, 0);
    rst_n = 1'b1; log_clr = 1'b0;
    tick(5);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] dev, sub, ptr, db;
      int nb, fill;
      logic [31:0] acc;
      bit match;
      dev = VEC[v][23:16]; sub = VEC[v][15:8]; nb = int'(VEC[v][7:0]);
      match = (dev == 8'h74);
      clear_log();
      i2c_start();
      send_byte(dev, ack);
      chk(ack == match, "R2 address ack", ack, match);
      send_byte(sub, ack);
      chk(ack == match, "R3 subaddress ack", ack, match);
      en = 0; ptr = sub; fill = 0; acc = 0;
      for (int k = 0; k < nb; k++) begin
        db = 8'(v * 16 + k + 1) ^ 8'hA5;
        send_byte(db, ack);
        chk(ack == match, "R3 data ack", ack, match);
        acc = (fill == 0) ? {24'h0, db} : {acc[23:0], db};
        fill++;
        if (match && fill == reg_len(ptr)) begin
          ea[en] = ptr; ed[en] = acc; en++;
          ptr = ptr + 8'd1; fill = 0;
        end
      end
      i2c_stop();
      tick(8);
      check_log("R2 R4 R5 R6 R7 R9 R10");
    end

    // R8: wide register broken off by a repeated START
    clear_log();
    i2c_start();
    send_byte(8'h74, ack);
    send_byte(8'h12, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    i2c_rstart();
    send_byte(8'h74, ack);
    chk(ack == 1'b1, "R8 address ack after repeated start", ack, 1);
    send_byte(8'h03, ack);
    send_byte(8'h5C, ack);
    i2c_stop();
    tick(8);
    en = 1; ea[0] = 8'h03; ed[0] = 32'h5C;
    check_log("R8");

    // R2: a rejected transfer stays silent until a repeated START
    clear_log();
    i2c_start();
    send_byte(8'h70, ack);
    chk(ack == 1'b0, "R2 foreign address nack", ack, 0);
    send_byte(8'h74, ack);
    chk(ack == 1'b0, "R2 ignored until start", ack, 0);
    i2c_rstart();
    send_byte(8'h74, ack);
    chk(ack == 1'b1, "R2 ack after new start", ack, 1);
    send_byte(8'h07, ack);
    send_byte(8'hE1, ack);
    i2c_stop();
    tick(8);
    en = 1; ea[0] = 8'h07; ed[0] = 32'hE1;
    check_log("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule